// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8051-style external memory bus: the address latch enable (ALE, active high) and the program store enable (`psen_n`, active low). It runs directly on the oscillator clock. A machine cycle is 12 oscillator periods, split into 6 slots of 2 periods each. The strobes are produced at fixed positions inside each machine cycle. Some pulses are dropped in cycles that perform an external data access.

At the start of every machine cycle the block decides whether that cycle fetches code from external memory. It bases this on the program counter and on the external-access pin level, which is captured during reset. It also takes in the core's "external data access this cycle" and "MOVX in progress" indications. A write port reaches one control bit. When that bit is set, the free-running ALE is suppressed, and ALE then pulses only in cycles that actually use the bus.

Top module: `bus_strobe_gen`

## Requirements
- R1: A machine cycle is 12 clock periods (phases 0 to 11, six slots of two). On the first clock edge after reset, and on every edge that follows phase 11, the block samples `pc`, `xdata_cycle`, `movx_active` and the ALE-disable bit. Those samples govern the whole machine cycle that starts at that edge. Input changes in the middle of a cycle have no effect until the next cycle.
- R2: ALE is high in phases 0–1 and 6–7 and low in all other phases. This gives two one-slot pulses per machine cycle, a rate of one sixth of the clock.
- R3: In a cycle sampled with `xdata_cycle`=1, the ALE pulse of phases 0–1 is omitted. The pulse in phases 6–7 is still produced, if ALE is allowed.
- R4: `psen_n` is active low. In an external-fetch cycle it is low in phases 2–5 and 8–11, which is two activations per cycle, and high in all other phases.
- R5: In a cycle sampled with `xdata_cycle`=1, both PSEN activations are omitted, so `psen_n` stays 1 for the whole cycle.
- R6: A cycle is an external fetch when the latched access level is 0, or when that level is 1 and `pc` is greater than 16'h0FFF. In every other cycle (an internal fetch), `psen_n` stays 1 for the whole cycle.
- R7: The access level is taken from `ea_pin` while `rst` is 1. Changes of `ea_pin` after reset is released do not affect the strobes.
- R8: A write with `cfg_we`=1 and `cfg_addr`=8'hAF loads the ALE-disable bit from `cfg_wdata0`. A write to any other address leaves the bit unchanged. A new value takes effect from the next machine cycle.
- R9: While the sampled ALE-disable bit is 1, ALE pulses only in cycles that are sampled with `movx_active`=1 or that are external fetches. In all other cycles ALE stays 0.
- R10: While `rst` is 1, `ale`=0 and `psen_n`=1. Reset clears the ALE-disable bit. The first edge after reset is released begins phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_pin | input | 1 | External-access pin level, latched during reset |
| pc | input | 16 | Program counter of the fetch in the coming cycle |
| xdata_cycle | input | 1 | The coming cycle performs an external data access |
| movx_active | input | 1 | A MOVX instruction is in progress |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 8 | Control register write address |
| cfg_wdata0 | input | 1 | Write data bit 0 (ALE-disable) |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |

## Verification
Several functions can act on ALE in the same cycle. When the ALE-disable bit is set, a cycle sampled with both `movx_active`=1 and `xdata_cycle`=1 is re-enabled by the MOVX flag but also loses its first pulse to the data-access skip. The sweep reaches this case in every combination of the disable bit, data flag, MOVX flag and fetch region. The expected result is a single pulse, in phases 6–7 only.

A second collision occurs when a control-register write lands on the edge that starts a cycle. The bench places its writes on exactly that edge. It expects the old setting for the whole current cycle and the new one only from the next cycle.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Attributes fixed for one machine cycle at its first edge
  typedef struct packed {
    logic ext;      // code fetch goes to external memory
    logic xd;       // external data access in this cycle
    logic movx;     // MOVX instruction in progress
    logic ale_off;  // free-running ALE suppressed
  } cyc_attr_t;

endpackage

// File: rtl/bstr_phase.sv
module bstr_phase #(
  parameter int CYC_OSC = 12,
  parameter int PH_W    = $clog2(CYC_OSC)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] nxt_phase,
  output logic            at_last
);

  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_OSC - 1);

  // Resting on the last phase in reset makes the first edge open phase 0
  always_ff @(posedge clk) begin
    if (rst) phase <= LAST;
    else     phase <= nxt_phase;
  end

  always_comb begin
    at_last   = (phase == LAST);
    nxt_phase = at_last ? '0 : phase + 1'b1;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST) |=> (phase == '0));

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/bstr_attr.sv
module bstr_attr
  import bus_strobe_pkg::*;
#(
  parameter int          PC_W      = 16,
  parameter int unsigned ROM_TOP   = 'h0FFF,
  parameter int          CFG_AW    = 8,
  parameter int unsigned CTRL_ADDR = 'hAF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ea_pin,
  input  logic [PC_W-1:0]   pc,
  input  logic              xdata_cycle,
  input  logic              movx_active,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wdata0,
  input  logic              at_last,
  output cyc_attr_t         nxt_attr
);

  localparam logic [PC_W-1:0]   ROM_TOP_V = PC_W'(ROM_TOP);
  localparam logic [CFG_AW-1:0] CTRL_A    = CFG_AW'(CTRL_ADDR);

  logic      ea_lat;
  logic      ale_off;
  logic      cfg_hit;
  cyc_attr_t fresh;
  cyc_attr_t held;

  assign cfg_hit = cfg_we && (cfg_addr == CTRL_A);

  always_comb begin
    fresh.ext     = !ea_lat || (pc > ROM_TOP_V);
    fresh.xd      = xdata_cycle;
    fresh.movx    = movx_active;
    fresh.ale_off = ale_off;
    nxt_attr      = at_last ? fresh : held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_lat  <= ea_pin;
      ale_off <= 1'b0;
      held    <= '0;
    end else begin
      if (cfg_hit) ale_off <= cfg_wdata0;
      if (at_last) held    <= fresh;
    end
  end

  p_ea_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ea_lat));

  p_cfg_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_hit |=> $stable(ale_off));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !at_last |=> $stable(held));

endmodule

// File: rtl/bstr_strobe.sv
module bstr_strobe
  import bus_strobe_pkg::*;
#(
  parameter int CYC_OSC = 12,
  parameter int SLOT    = 2,
  parameter int PH_W    = $clog2(CYC_OSC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] nxt_phase,
  input  cyc_attr_t       attr,
  output logic            ale,
  output logic            psen_n
);

  localparam int NSLOT = CYC_OSC / SLOT;
  localparam int HALF  = NSLOT / 2;

  logic ale_d;
  logic psen_n_d;
  logic allow;
  int   slot_n;

  always_comb begin
    slot_n   = int'(nxt_phase) / SLOT;
    allow    = !attr.ale_off || attr.movx || attr.ext;
    ale_d    = allow && (((slot_n == 0) && !attr.xd) || (slot_n == HALF));
    psen_n_d = !(attr.ext && !attr.xd && (slot_n != 0) && (slot_n != HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_d;
      psen_n <= psen_n_d;
    end
  end

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  p_xd_no_psen_r5: assert property (@(posedge clk) disable iff (rst)
    attr.xd |=> psen_n);

  p_ale_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (attr.ale_off && !attr.movx && !attr.ext) |=> !ale);

  p_int_no_psen_r6: assert property (@(posedge clk) disable iff (rst)
    !attr.ext |=> psen_n);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int          CYC_OSC   = 12,
  parameter int          SLOT      = 2,
  parameter int          PC_W      = 16,
  parameter int unsigned ROM_TOP   = 'h0FFF,
  parameter int          CFG_AW    = 8,
  parameter int unsigned CTRL_ADDR = 'hAF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ea_pin,
  input  logic [PC_W-1:0]   pc,
  input  logic              xdata_cycle,
  input  logic              movx_active,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wdata0,
  output logic              ale,
  output logic              psen_n
);

  localparam int PH_W = $clog2(CYC_OSC);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] nxt_phase;
  logic            at_last;
  cyc_attr_t       nxt_attr;

  bstr_phase #(.CYC_OSC(CYC_OSC), .PH_W(PH_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .nxt_phase (nxt_phase),
    .at_last   (at_last)
  );

  bstr_attr #(
    .PC_W(PC_W), .ROM_TOP(ROM_TOP), .CFG_AW(CFG_AW), .CTRL_ADDR(CTRL_ADDR)
  ) u_attr (
    .clk         (clk),
    .rst         (rst),
    .ea_pin      (ea_pin),
    .pc          (pc),
    .xdata_cycle (xdata_cycle),
    .movx_active (movx_active),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata0  (cfg_wdata0),
    .at_last     (at_last),
    .nxt_attr    (nxt_attr)
  );

  bstr_strobe #(.CYC_OSC(CYC_OSC), .SLOT(SLOT), .PH_W(PH_W)) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .nxt_phase (nxt_phase),
    .attr      (nxt_attr),
    .ale       (ale),
    .psen_n    (psen_n)
  );

  // R1: a fresh cycle opens only on the edge after the last phase
  p_open_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> $past(at_last));

endmodule

// File: tb/bus_strobe_gen_bench.sv
`timescale 1ns/1ps
module bus_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ea_pin = 1'b1;
  logic [15:0] pc = '0;
  logic        xdata_cycle = 1'b0;
  logic        movx_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wdata0 = 1'b0;
  logic        ale;
  logic        psen_n;

  int checks = 0;
  int errors = 0;
  logic ea_ref = 1'b1;
  logic eff_off = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst(rst), .ea_pin(ea_pin), .pc(pc),
    .xdata_cycle(xdata_cycle), .movx_active(movx_active),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata0(cfg_wdata0),
    .ale(ale), .psen_n(psen_n)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic ea);
    @(posedge clk); #1;
    rst = 1'b1; ea_pin = ea; cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R10", "ale in reset", ale, 1'b0);
    check("R10", "psen_n in reset", psen_n, 1'b1);
    ea_ref = ea;
    eff_off = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cycle(input logic [15:0] p, input logic x, input logic m,
                           input logic do_wr, input logic [7:0] wa, input logic wd,
                           input logic mid, input string tag);
    logic ext, allow, ale_e, psen_e;
    string ta, tp;
    pc = p; xdata_cycle = x; movx_active = m;
    cfg_we = do_wr; cfg_addr = wa; cfg_wdata0 = wd;
    ext   = !ea_ref || (p > 16'h0FFF);
    allow = !eff_off || m || ext;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      cfg_we = 1'b0;
      ale_e  = allow && (((k < 2) && !x) || (k == 6) || (k == 7));
      psen_e = !(ext && !x && (k >= 2) && (k != 6) && (k != 7));
      if (tag != "") begin ta = tag; tp = tag; end
      else begin
        ta = (x && k < 2) ? "R3" : (!allow ? "R9" : "R2");
        tp = x ? "R5" : (!ext ? "R6" : "R4");
      end
      check(ta, $sformatf("ale phase %0d", k), ale, ale_e);
      check(tp, $sformatf("psen_n phase %0d", k), psen_n, psen_e);
      if (mid && k == 5) begin
        pc = ~p; xdata_cycle = ~x; movx_active = ~m;
      end
    end
    if (do_wr && wa == 8'hAF) eff_off = wd;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pcs [4];
    pcs[0] = 16'h0000; pcs[1] = 16'h0FFF; pcs[2] = 16'h1000; pcs[3] = 16'hFFFF;
    for (int e = 0; e < 2; e++) begin
      do_reset(e[0]);
      // R10: first cycle starts at phase 0 with ALE enabled
      run_cycle(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R10");
      for (int o = 0; o < 2; o++) begin
        // R8: write lands on the cycle-opening edge; old setting this cycle
        run_cycle(16'h0000, 1'b0, 1'b0, 1'b1, 8'hAF, o[0], 1'b0, "R8");
        for (int pi = 0; pi < 4; pi++)
          for (int x = 0; x < 2; x++)
            for (int m = 0; m < 2; m++)
              run_cycle(pcs[pi], x[0], m[0], 1'b0, 8'h00, 1'b0,
                        (pi == 1), (pi == 1) ? "R1" : "");
      end
      // R8: write to another address leaves the disable bit set
      run_cycle(16'h0000, 1'b0, 1'b0, 1'b1, 8'hAE, 1'b0, 1'b0, "R8");
      run_cycle(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
      // R7: flip the pin after reset; the latched level still rules
      ea_pin = ~ea_ref;
      run_cycle(16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
      run_cycle(16'h0800, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule